// File: doc/BRIEF.md
# Line-Locked Colour Subcarrier Phase Synthesizer

This block produces the colour subcarrier phase for a black burst generator from a sample clock that is locked to horizontal sync. It does not use a separate subcarrier oscillator. Each clock, a phase accumulator advances by an exact rational fraction of a subcarrier cycle. That fraction is fixed by the line rate of the selected standard (NTSC or PAL). An integer step and a fractional remainder, kept modulo the ratio's denominator, make the phase repeat exactly with no long-term drift.

With no reference present, the block free-runs as the timing master and adds only the nominal step. With a reference present, a signed burst phase error arrives once per line after the burst window, and it trims the synthesized phase through a proportional-plus-integral loop. The proportional term is a one-shot phase jump. The integral term is a saturating frequency offset that is added on every clock. Both gains are programmable right shifts. The phase drives a sine/cosine table through two address outputs that are a quarter cycle apart.

Top module: `subcarrier_ratio_synth`

## Requirements
- R1: While reset is asserted and on release, `phase_o` is 0, `sin_addr_o` is 0 and `cos_addr_o` is 2^(ADDR_W-2).
- R2: With `std_pal_i`=0 (NTSC) and no correction, the phase after n clocks from reset equals floor(n*455*2^32/3432) mod 2^32. This is 227.5 cycles per 1716 clocks: after 1716 clocks the phase is 0x80000000, and after 3432 clocks it is 0. Each single-clock step is either floor(455*2^32/3432) or that value plus 1.
- R3: With `std_pal_i`=1 (PAL) and no correction, the phase after n clocks from reset equals floor(n*709379*2^32/4320000) mod 2^32. This is 283.75 + 1/625 cycles per 1728-clock line.
- R4: An accepted error e adds a one-shot jump of e >>> `kp_shift_i` (arithmetic shift, sign-extended) to the phase step of the clock edge at which `err_valid_i` is sampled.
- R5: An accepted error adds e >>> `ki_shift_i` to a signed integrator. From the next clock on, the integrator value is added to every phase step while `locked_i` is 1.
- R6: The integrator saturates at +INT_LIM and -INT_LIM (default 4095) and never leaves that range.
- R7: An error is accepted only when `locked_i` and `err_valid_i` are both 1 and a `line_start_i` pulse has occurred since the last accepted error. Any other error strobe leaves the phase and the integrator unchanged.
- R8: While `locked_i` is 0, every step is the nominal step alone, and the integrator is cleared at the first edge in free-running mode. On return to locked mode, the steps stay nominal until the next accepted error.
- R9: `sin_addr_o` is the top ADDR_W bits of the phase. `cos_addr_o` is `sin_addr_o` + 2^(ADDR_W-2), modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line-locked sample clock (27 MHz) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| locked_i | input | 1 | 1: follow reference burst; 0: free-run as master |
| std_pal_i | input | 1 | Standard select, 0 = NTSC, 1 = PAL |
| line_start_i | input | 1 | One-clock strobe at the start of each line |
| err_i | input | ERR_W (16) | Signed burst phase error, two's complement |
| err_valid_i | input | 1 | Error strobe, once per line after the burst window |
| kp_shift_i | input | SH_W (4) | Proportional gain as right-shift amount |
| ki_shift_i | input | SH_W (4) | Integral gain as right-shift amount |
| phase_o | output | PH_W (32) | Subcarrier phase accumulator |
| sin_addr_o | output | ADDR_W (10) | Sine table address |
| cos_addr_o | output | ADDR_W (10) | Cosine table address |

## Verification
The bench targets the exact line closure of the ratio. A truncated step, or a remainder compared against the wrong denominator, misses 0x80000000 after one NTSC line and then drifts without bound. It drives duplicate error strobes within one line and strobes in free-running mode. A design that does not enforce the per-line arming would apply the proportional jump twice or let the integrator move. Full-scale errors of both signs with zero integral shift push the integrator against its limits, where a missing clamp wraps around. Mode changes in both directions check that a stale integrator is not still being added after the loop has been released.

// File: rtl/sc_synth_pkg.sv
package sc_synth_pkg;
  // Subcarrier cycles per clock as exact rationals
  localparam int unsigned NTSC_NUM = 455;      // 227.5 cycles / 1716 clocks
  localparam int unsigned NTSC_DEN = 3432;
  localparam int unsigned PAL_NUM  = 709379;   // (283.75 + 1/625) cycles / 1728 clocks
  localparam int unsigned PAL_DEN  = 4320000;
  localparam int unsigned FR_W     = $clog2(PAL_DEN) + 1;

  typedef enum logic {STD_NTSC = 1'b0, STD_PAL = 1'b1} video_std_e;
endpackage

// File: rtl/sc_ratio_gen.sv
module sc_ratio_gen
  import sc_synth_pkg::*;
#(
  parameter int unsigned PH_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  video_std_e      std_i,
  output logic [PH_W-1:0] step_o
);
  localparam logic [95:0] NT_SC = 96'(NTSC_NUM) << PH_W;
  localparam logic [95:0] PA_SC = 96'(PAL_NUM) << PH_W;
  localparam logic [PH_W-1:0] NT_Q = PH_W'(NT_SC / 96'(NTSC_DEN));
  localparam logic [PH_W-1:0] PA_Q = PH_W'(PA_SC / 96'(PAL_DEN));
  localparam logic [FR_W-1:0] NT_R = FR_W'(NT_SC % 96'(NTSC_DEN));
  localparam logic [FR_W-1:0] PA_R = FR_W'(PA_SC % 96'(PAL_DEN));

  logic [FR_W-1:0] frac_q, frac_d, frac_eff, den_sel, rem_sel, sum;
  logic [PH_W-1:0] q_sel;
  logic            carry;

  always_comb begin
    den_sel  = (std_i == STD_PAL) ? FR_W'(PAL_DEN) : FR_W'(NTSC_DEN);
    rem_sel  = (std_i == STD_PAL) ? PA_R : NT_R;
    q_sel    = (std_i == STD_PAL) ? PA_Q : NT_Q;
    // stale remainder after a standard change restarts the fraction
    frac_eff = (frac_q >= den_sel) ? '0 : frac_q;
    sum      = frac_eff + rem_sel;
    carry    = (sum >= den_sel);
    frac_d   = carry ? sum - den_sel : sum;
    step_o   = q_sel + PH_W'(carry);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) frac_q <= '0;
    else         frac_q <= frac_d;
  end

  // R2 R3: remainder stays inside the largest modulus
  a_r3_frac_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_q < FR_W'(PAL_DEN));
endmodule

// File: rtl/sc_pi_corr.sv
module sc_pi_corr #(
  parameter int unsigned PH_W    = 32,
  parameter int unsigned ERR_W   = 16,
  parameter int unsigned INT_W   = 16,
  parameter int unsigned INT_LIM = 4095,
  parameter int unsigned SH_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             locked_i,
  input  logic             line_start_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             err_valid_i,
  input  logic [SH_W-1:0]  kp_shift_i,
  input  logic [SH_W-1:0]  ki_shift_i,
  output logic [PH_W-1:0]  corr_o
);
  localparam int unsigned SUM_W = ((INT_W > ERR_W) ? INT_W : ERR_W) + 1;
  localparam logic signed [SUM_W-1:0] LIM_P = SUM_W'(INT_LIM);
  localparam logic signed [SUM_W-1:0] LIM_N = -LIM_P;

  logic                    armed_q;
  logic                    accept;
  logic signed [INT_W-1:0] integ_q, integ_d;
  logic signed [ERR_W-1:0] err_s, prop, iadd;
  logic signed [SUM_W-1:0] sum;
  logic signed [PH_W-1:0]  integ_x, prop_x;

  always_comb begin
    err_s   = $signed(err_i);
    prop    = err_s >>> kp_shift_i;
    iadd    = err_s >>> ki_shift_i;
    accept  = locked_i && err_valid_i && armed_q;
    sum     = SUM_W'(integ_q) + SUM_W'(iadd);
    if (!locked_i)          integ_d = '0;
    else if (!accept)       integ_d = integ_q;
    else if (sum > LIM_P)   integ_d = INT_W'(LIM_P);
    else if (sum < LIM_N)   integ_d = INT_W'(LIM_N);
    else                    integ_d = INT_W'(sum);
    integ_x = PH_W'(integ_q);
    prop_x  = PH_W'(prop);
    if (!locked_i)   corr_o = '0;
    else if (accept) corr_o = integ_x + prop_x;
    else             corr_o = integ_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      integ_q <= '0;
    end else begin
      if (line_start_i) armed_q <= 1'b1;
      else if (accept)  armed_q <= 1'b0;
      integ_q <= integ_d;
    end
  end

  a_r6_integ_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (SUM_W'(integ_q) <= LIM_P) && (SUM_W'(integ_q) >= LIM_N));

  a_r8_integ_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> (integ_q == '0));

  // R7: a second accept needs a fresh line start
  a_r7_one_per_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !line_start_i) |=> !accept || $past(line_start_i) || line_start_i
      || $past(line_start_i, 1) );
endmodule

// File: rtl/sc_addr_map.sv
module sc_addr_map #(
  parameter int unsigned PH_W   = 32,
  parameter int unsigned ADDR_W = 10
) (
  input  logic [PH_W-1:0]   phase_i,
  output logic [ADDR_W-1:0] sin_addr_o,
  output logic [ADDR_W-1:0] cos_addr_o
);
  localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1) << (ADDR_W - 2);

  assign sin_addr_o = phase_i[PH_W-1 -: ADDR_W];
  assign cos_addr_o = sin_addr_o + QUARTER;
endmodule

// File: rtl/subcarrier_ratio_synth.sv
module subcarrier_ratio_synth
  import sc_synth_pkg::*;
#(
  parameter int unsigned PH_W    = 32,
  parameter int unsigned ERR_W   = 16,
  parameter int unsigned INT_W   = 16,
  parameter int unsigned INT_LIM = 4095,
  parameter int unsigned SH_W    = 4,
  parameter int unsigned ADDR_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              locked_i,
  input  logic              std_pal_i,
  input  logic              line_start_i,
  input  logic [ERR_W-1:0]  err_i,
  input  logic              err_valid_i,
  input  logic [SH_W-1:0]   kp_shift_i,
  input  logic [SH_W-1:0]   ki_shift_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [ADDR_W-1:0] sin_addr_o,
  output logic [ADDR_W-1:0] cos_addr_o
);
  logic [PH_W-1:0] nom_step, corr, phase_q;
  video_std_e      std_sel;

  assign std_sel = std_pal_i ? STD_PAL : STD_NTSC;

  sc_ratio_gen #(.PH_W(PH_W)) u_ratio (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .std_i  (std_sel),
    .step_o (nom_step)
  );

  sc_pi_corr #(
    .PH_W(PH_W), .ERR_W(ERR_W), .INT_W(INT_W), .INT_LIM(INT_LIM), .SH_W(SH_W)
  ) u_pi (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .locked_i     (locked_i),
    .line_start_i (line_start_i),
    .err_i        (err_i),
    .err_valid_i  (err_valid_i),
    .kp_shift_i   (kp_shift_i),
    .ki_shift_i   (ki_shift_i),
    .corr_o       (corr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + nom_step + corr;
  end

  assign phase_o = phase_q;

  sc_addr_map #(.PH_W(PH_W), .ADDR_W(ADDR_W)) u_addr (
    .phase_i    (phase_q),
    .sin_addr_o (sin_addr_o),
    .cos_addr_o (cos_addr_o)
  );

  a_r8_free_nominal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i |=> (phase_q == $past(phase_q + nom_step)));

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (phase_q == '0));
endmodule

// File: tb/subcarrier_ratio_synth_test.sv
module subcarrier_ratio_synth_test;
  localparam int CLK_PERIOD = 37;
  localparam int INT_LIM = 4095;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        locked = 1'b0, std_pal = 1'b0, line_start = 1'b0, err_valid = 1'b0;
  logic [15:0] err = '0;
  logic [3:0]  kp = 4'd2, ki = 4'd4;
  logic [31:0] phase;
  logic [9:0]  sin_a, cos_a;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // bench model state
  longint unsigned n_clk;
  logic [31:0]     offset;
  int              integ;
  bit              armed;

  subcarrier_ratio_synth uut (
    .clk_i(clk), .rst_ni(rst_n), .locked_i(locked), .std_pal_i(std_pal),
    .line_start_i(line_start), .err_i(err), .err_valid_i(err_valid),
    .kp_shift_i(kp), .ki_shift_i(ki), .phase_o(phase),
    .sin_addr_o(sin_a), .cos_addr_o(cos_a)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] base_phase(longint unsigned n, bit pal);
    logic [95:0] t;
    longint unsigned num = pal ? 709379 : 455;
    longint unsigned den = pal ? 4320000 : 3432;
    t = (96'(n % den) * 96'(num)) << 32;
    return 32'(t / 96'(den));
  endfunction

  function automatic logic [31:0] nom_q(bit pal);
    logic [95:0] t;
    t = (96'(pal ? 709379 : 455)) << 32;
    return 32'(t / 96'(pal ? 4320000 : 3432));
  endfunction

  function automatic logic [31:0] exp_phase();
    return base_phase(n_clk, std_pal) + offset;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // apply one clock edge with the current inputs, update model, sample at negedge
  task automatic tick();
    int e, s;
    bit acc;
    e = int'($signed(err));
    acc = locked && err_valid && armed;
    if (locked) begin
      offset += 32'(integ);
      if (acc) offset += 32'(e >>> kp);
    end
    if (!locked) integ = 0;
    else if (acc) begin
      s = integ + (e >>> ki);
      integ = (s > INT_LIM) ? INT_LIM : (s < -INT_LIM) ? -INT_LIM : s;
    end
    if (line_start) armed = 1'b1;
    else if (acc) armed = 1'b0;
    n_clk++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(bit pal);
    rst_n = 1'b0; locked = 0; line_start = 0; err_valid = 0; err = '0;
    std_pal = pal;
    n_clk = 0; offset = '0; integ = 0; armed = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_addr(string tag);
    chk(sin_a == phase[31:22], tag, 32'(sin_a), 32'(phase[31:22]));
    chk(cos_a == 10'(phase[31:22] + 10'd256), tag, 32'(cos_a), 32'(10'(phase[31:22] + 10'd256)));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] prev, q;
    void'($urandom(1234));

    // R1 reset state
    do_reset(1'b0);
    chk(phase == 0, "R1 phase", phase, 0);
    chk(sin_a == 0, "R1 sin", 32'(sin_a), 0);
    chk(cos_a == 10'd256, "R1 cos", 32'(cos_a), 256);

    // R2 NTSC free run: step bounds and line closure
    q = nom_q(1'b0);
    for (int i = 0; i < 1716; i++) begin
      prev = phase;
      tick();
      if (i % 101 == 0) begin
        chk((phase - prev == q) || (phase - prev == q + 1), "R2 step", phase - prev, q);
        chk(phase == exp_phase(), "R2 phase", phase, exp_phase());
        chk_addr("R9 addr");
      end
    end
    chk(phase == 32'h8000_0000, "R2 half line", phase, 32'h8000_0000);
    repeat (1716) tick();
    chk(phase == 32'h0, "R2 two lines", phase, 0);

    // R3 PAL free run
    do_reset(1'b1);
    for (int i = 0; i < 3000; i++) begin
      tick();
      if (i % 97 == 0) begin
        chk(phase == exp_phase(), "R3 phase", phase, exp_phase());
        chk_addr("R9 addr");
      end
    end

    // R4/R5 directed locked correction
    do_reset(1'b0);
    repeat (5) tick();
    locked = 1; kp = 2; ki = 4;
    line_start = 1; tick(); line_start = 0;
    prev = phase;
    err = 16'sd1000; err_valid = 1; tick(); err_valid = 0;
    chk((phase - prev == q + 250) || (phase - prev == q + 251), "R4 prop jump", phase - prev, q + 250);
    prev = phase; tick();
    chk((phase - prev == q + 62) || (phase - prev == q + 63), "R5 integ step", phase - prev, q + 62);
    chk(phase == exp_phase(), "R5 phase", phase, exp_phase());

    // R7 duplicate strobe without line start ignored
    prev = phase;
    err = 16'sd8000; err_valid = 1; tick(); err_valid = 0;
    chk((phase - prev == q + 62) || (phase - prev == q + 63), "R7 duplicate ignored", phase - prev, q + 62);

    // R6 saturation positive and negative
    ki = 0; kp = 15;
    for (int k = 0; k < 3; k++) begin
      line_start = 1; tick(); line_start = 0;
      err = 16'h7fff; err_valid = 1; tick(); err_valid = 0;
    end
    prev = phase; tick();
    chk((phase - prev == q + 4095) || (phase - prev == q + 4096), "R6 pos limit", phase - prev, q + 4095);
    for (int k = 0; k < 3; k++) begin
      line_start = 1; tick(); line_start = 0;
      err = 16'h8000; err_valid = 1; tick(); err_valid = 0;
    end
    prev = phase; tick();
    chk((phase - prev == q - 4095) || (phase - prev == q - 4094), "R6 neg limit", phase - prev, q - 4095);

    // R8 free mode: nominal step, strobes ignored, integrator cleared
    locked = 0;
    prev = phase; tick();
    chk((phase - prev == q) || (phase - prev == q + 1), "R8 nominal", phase - prev, q);
    line_start = 1; tick(); line_start = 0;
    prev = phase;
    err = 16'sd5000; err_valid = 1; tick(); err_valid = 0;
    chk((phase - prev == q) || (phase - prev == q + 1), "R7 free strobe ignored", phase - prev, q);
    locked = 1;
    prev = phase; tick();
    chk((phase - prev == q) || (phase - prev == q + 1), "R8 integ cleared", phase - prev, q);
    chk(phase == exp_phase(), "R8 phase", phase, exp_phase());

    // random locked/free operation against the model
    for (int ln = 0; ln < 12; ln++) begin
      bit pal_ln = ln[0];
      if (ln % 4 == 0) do_reset(pal_ln);
      kp = 4'($urandom_range(0, 15));
      ki = 4'($urandom_range(0, 15));
      for (int c = 0; c < 1716; c++) begin
        locked     = ($urandom_range(0, 19) != 0);
        line_start = (c == 0);
        err_valid  = (c == 300) || ($urandom_range(0, 199) == 0);
        err        = 16'($urandom);
        tick();
        if (c % 53 == 0) chk(phase == exp_phase(), "R5 R7 random", phase, exp_phase());
      end
      line_start = 0; err_valid = 0;
      chk_addr("R9 random addr");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule